// File: doc/BRIEF.md
# DMA Request Sampler with Acknowledge

This block turns an active-low DMA request pin into a counted queue of transfer requests. It samples the pin on every rising edge of the bus clock while the channel is enabled. A two-flop synchronizer sits in front of the sampling point. Each recognised low level adds one entry to a small counter that stands in for a request queue. The transfer engine sees a pending flag whenever the count is nonzero. When the engine starts a transfer cycle, it pulses a cycle-start strobe. If a request is queued, the block answers that strobe in the same clock with an acknowledge pulse and removes one entry.

A mode input selects between two queue depths. The shallow setting holds one entry and stops sampling until an acknowledge has emptied it. The deep setting holds up to sixteen entries, and it can add and remove an entry in the same clock. In both settings the first clock edge after the channel is enabled is discarded to reject noise. Because of the synchronizer and the queue, a request that is withdrawn at the moment it is acknowledged still yields exactly one more transfer. The block knows nothing about how the engine addresses or paces its transfers.

Top module: `dreq_sampler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, count is 0, pending is 0 and ack is 0.
- R2: A low level on req_n reaches the sampling point through two synchronizer flops. When req_n goes low while sampling is armed, count first rises at the third rising edge after the change.
- R3: The first rising edge at which en is high after a low period, or after reset, takes no sample, even when the request is low. Sampling starts at the second such edge.
- R4: With deep_mode = 0 (shallow), one captured sample makes count 1. count stays at 1 while the request is held low and no acknowledge arrives.
- R5: With deep_mode = 0, a new sample is taken only when count is 0 at the edge. After an acknowledge empties the queue, count reads 0 for one cycle before a held request refills it.
- R6: ack is high exactly when cyc_start is high, en is high and count is nonzero. count drops by one at the edge that ends that ack cycle, and a strobe with an empty queue gives no ack. pending equals (count != 0).
- R7: With deep_mode = 1, a sample and an acknowledge at the same edge leave count unchanged.
- R8: With deep_mode = 1, count saturates at 16. Samples taken while the queue is full and no acknowledge is present are dropped.
- R9: If req_n is raised in the same cycle that an ack is given, exactly one further sample is captured, so one more ack is served before requests stop.
- R10: When en is low, count is 0 after the next edge, ack is 0 and the noise-rejection state is cleared. Re-enabling again ignores its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low clears the queue and disarms sampling |
| deep_mode | input | 1 | 0 selects the 1-entry queue, 1 selects the 16-entry queue |
| req_n | input | 1 | Active-low external DMA request pin, asynchronous |
| cyc_start | input | 1 | One-cycle strobe from the transfer engine marking the start of a transfer cycle |
| ack | output | 1 | Acknowledge pulse, one per queued sample, coincident with cyc_start |
| pending | output | 1 | High while at least one request is queued |
| count | output | 5 | Number of queued requests |

## Verification
The hardest case to reach is the same-edge increment and decrement in deep mode, away from both the empty and the full boundary. A lone pulse of the request pin cannot reach it, because the sample lands two edges after the pin changes. The stimulus first fills the queue to saturation and then withdraws the request. It waits for the synchronizer to drain and drains three entries with strobes. It then lowers the request again, lets two edges pass so that the synchronized level is low, and only then raises the strobe. The one-extra-transfer case uses the same counting of synchronizer edges. There the pin is raised in the very cycle the acknowledge is given.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    // Queue depth selection carried on the deep_mode pin
    typedef enum logic {
        QMODE_SHALLOW = 1'b0,
        QMODE_DEEP    = 1'b1
    } qmode_e;

    localparam int unsigned DEF_DEEP_DEPTH  = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dreq_sync.sv
// Multi-flop synchronizer for the asynchronous request pin; idles high.
module dreq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_n
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = pin_n;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], pin_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_n = chain_q[STAGES-1];
endmodule

// File: rtl/dreq_gate.sv
// Noise rejection: the first enabled edge only arms sampling.
module dreq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level_n,
    output logic take
);
    typedef struct packed {
        logic armed;
    } gate_t;

    gate_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.armed = en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take = en && st_q.armed && !level_n;
endmodule

// File: rtl/dreq_queue.sv
// Counter-based request queue with acknowledge generation.
module dreq_queue
    import dreq_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEEP_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  qmode_e        mode,
    input  logic          take,
    input  logic          cyc_start,
    output logic          ack,
    output logic          pending,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_DEEP = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } queue_t;

    queue_t st_q, st_d;
    logic   dec;
    logic   inc;
    logic   room;

    always_comb begin
        dec = en && cyc_start && (st_q.cnt != '0);
        unique case (mode)
            QMODE_SHALLOW: room = (st_q.cnt == '0);
            QMODE_DEEP:    room = (st_q.cnt != FULL_DEEP) || dec;
            default:       room = 1'b0;
        endcase
        inc = take && room;

        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else begin
            case ({inc, dec})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack     = dec;
    assign pending = (st_q.cnt != '0);
    assign count   = st_q.cnt;
endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler
    import dreq_pkg::*;
#(
    parameter int unsigned DEPTH       = DEF_DEEP_DEPTH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          deep_mode,
    input  logic          req_n,
    input  logic          cyc_start,
    output logic          ack,
    output logic          pending,
    output logic [CW-1:0] count
);
    logic   req_sync_n;
    logic   take;
    qmode_e mode;

    assign mode = deep_mode ? QMODE_DEEP : QMODE_SHALLOW;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (req_n),
        .level_n (req_sync_n)
    );

    dreq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .level_n (req_sync_n),
        .take    (take)
    );

    dreq_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode      (mode),
        .take      (take),
        .cyc_start (cyc_start),
        .ack       (ack),
        .pending   (pending),
        .count     (count)
    );
endmodule

// File: rtl/dreq_sampler_chk.sv
module dreq_sampler_chk #(
    parameter int unsigned CW    = 5,
    parameter int unsigned DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          deep_mode,
    input logic          cyc_start,
    input logic          ack,
    input logic          pending,
    input logic [CW-1:0] count
);
    // R6
    ack_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (pending && cyc_start && en));

    // R6
    shallow_ack_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !deep_mode && count == CW'(1)) |=> (count == '0));

    // R4
    shallow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep_mode && $past(!deep_mode) && $past(count <= CW'(1))) |-> (count <= CW'(1)));

    // R8
    deep_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0));

    // R3
    first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (!en || count == '0));
endmodule

bind dreq_sampler dreq_sampler_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .deep_mode (deep_mode),
    .cyc_start (cyc_start),
    .ack       (ack),
    .pending   (pending),
    .count     (count)
);

// File: tb/sim_dreq_sampler.sv
`timescale 1ns/1ps
module sim_dreq_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       deep_mode = 1'b0;
    logic       req_n = 1'b1;
    logic       cyc_start = 1'b0;
    logic       ack;
    logic       pending;
    logic [4:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dreq_sampler u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .deep_mode (deep_mode),
        .req_n     (req_n),
        .cyc_start (cyc_start),
        .ack       (ack),
        .pending   (pending),
        .count     (count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        tick(2);
        chk("R1 count in reset", count, 0);
        chk("R1 pending in reset", pending, 0);
        chk("R1 ack in reset", ack, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 count after release", count, 0);
        chk("R1 ack after release", ack, 0);
    endtask

    task automatic t_shallow;
        deep_mode = 1'b0; req_n = 1'b0; en = 1'b0;
        tick(4);
        en = 1'b1;
        tick(1);
        chk("R3 first edge ignored", count, 0);
        tick(1);
        chk("R4 one sample fills", count, 1);
        chk("R6 pending with entry", pending, 1);
        tick(3);
        chk("R4 held at one", count, 1);
        cyc_start = 1'b1; #1;
        chk("R6 ack on strobe", ack, 1);
        tick(1); cyc_start = 1'b0;
        chk("R5 emptied by ack", count, 0);
        chk("R6 pending drops", pending, 0);
        tick(1);
        chk("R5 refill after empty", count, 1);
    endtask

    task automatic t_overrun;
        cyc_start = 1'b1; req_n = 1'b1; #1;
        chk("R9 ack given", ack, 1);
        tick(1); cyc_start = 1'b0;
        chk("R9 empty after ack", count, 0);
        tick(1);
        chk("R9 extra sample", count, 1);
        cyc_start = 1'b1; #1;
        chk("R9 extra ack", ack, 1);
        tick(1); cyc_start = 1'b0;
        tick(3);
        chk("R9 requests stop", count, 0);
        cyc_start = 1'b1; #1;
        chk("R6 no ack when empty", ack, 0);
        tick(1); cyc_start = 1'b0;
        chk("R6 empty stays empty", count, 0);
    endtask

    task automatic t_disable;
        req_n = 1'b0;
        tick(4);
        chk("R10 refilled before disable", count, 1);
        en = 1'b0; cyc_start = 1'b1; #1;
        chk("R10 no ack while disabled", ack, 0);
        tick(1); cyc_start = 1'b0;
        chk("R10 cleared", count, 0);
        tick(2);
        en = 1'b1;
        tick(1);
        chk("R10 rearm ignores first edge", count, 0);
        tick(1);
        chk("R10 samples after rearm", count, 1);
    endtask

    task automatic t_deep;
        en = 1'b0; req_n = 1'b1; deep_mode = 1'b1;
        tick(3);
        en = 1'b1;
        tick(3);
        req_n = 1'b0;
        tick(2);
        chk("R2 no sample within sync", count, 0);
        tick(1);
        chk("R2 sample on third edge", count, 1);
        tick(4);
        chk("R8 deep accumulates", count, 5);
        tick(20);
        chk("R8 saturates", count, 16);
        cyc_start = 1'b1; #1;
        chk("R7 ack at full", ack, 1);
        tick(1); cyc_start = 1'b0;
        chk("R7 full balance", count, 16);
        req_n = 1'b1;
        tick(3);
        chk("R8 dropped at full", count, 16);
        cyc_start = 1'b1;
        tick(3); cyc_start = 1'b0;
        chk("R6 deep drain", count, 13);
        req_n = 1'b0;
        tick(2);
        chk("R7 before balance", count, 13);
        cyc_start = 1'b1;
        tick(1); cyc_start = 1'b0;
        chk("R7 mid balance", count, 13);
        tick(1);
        chk("R7 increment resumes", count, 14);
    endtask

    initial begin
        t_reset();
        t_shallow();
        t_overrun();
        t_disable();
        t_deep();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule